// File: doc/BRIEF.md
# Power Control Register with Cold-Boot Flag

This block is the power-control special function register of an 8-bit controller core. It holds two low-power mode bits (idle and power-down), two general-purpose user flags, and a cold-boot flag that only a power-on reset can set. From the mode bits it drives three clock enables: one for the CPU clock, one for the peripheral clock, and one for the oscillator. The analog oscillator, the reset circuit and the core pipeline sit outside the block. The block only stores the state and produces the enables.

Software writes the register over the SFR bus at address 87h and reads it back through a combinational read port. After any reset, software reads the cold-boot flag to tell a power-up from a warm restart, and may then clear the flag. Idle mode is left when an enabled interrupt arrives. Power-down mode is left on a reset or, when the variant is built with it, on an external wake event.

Top module: `pwr_ctl_reg`

## Requirements
- R1: Reading address 87h returns {000, POF, GF1, GF0, PD, IDL}, with POF in bit 4, GF1 in bit 3, GF0 in bit 2, PD in bit 1 and IDL in bit 0. Bits 7..5 always read 0. Any other address reads 00h. The read is combinational on the address.
- R2: A power-on reset (por_i high at a clock edge) sets POF to 1 and clears GF1, GF0, PD and IDL. The register then reads 10h and all three enables are high.
- R3: A general reset (sys_rst_i high, por_i low) clears GF1, GF0, PD and IDL and leaves POF unchanged.
- R4: A write to 87h with bit 4 equal to 0 clears POF. A write with bit 4 equal to 1 leaves POF unchanged, because only a power-on reset sets it.
- R5: GF1 and GF0 store the written bits 3 and 2. They have no effect on the enables.
- R6: Writing IDL=1 with PD=0 drops cpu_clk_en_o from the next cycle. per_clk_en_o and osc_en_o stay high.
- R7: Writing PD=1 drops all three enables from the next cycle.
- R8: A write with both PD=1 and IDL=1 stores PD=1 and IDL=0. The register reads back with bit 1 set and bit 0 clear.
- R9: irq_wake_i clears IDL, so cpu_clk_en_o is high in the next cycle. irq_wake_i does not clear PD.
- R10: With PD_WAKE_EXT=1, ext_wake_i clears both PD and IDL, so all enables are high in the next cycle.
- R11: When a wake event arrives in the same cycle as a register write, the wake wins for the mode bits it clears. The flag bits still take the written values.
- R12: Writes to any address other than 87h change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, synchronous, active high |
| sys_rst_i | input | 1 | General reset, synchronous, active high |
| sfr_addr_i | input | ADDR_W | SFR bus address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | DATA_W | SFR write data |
| sfr_rdata_o | output | DATA_W | SFR read data, combinational |
| irq_wake_i | input | 1 | Any enabled interrupt is pending |
| ext_wake_i | input | 1 | External interrupt wake event |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
Every register update, whether from a write, a reset or a wake, takes effect at the clock edge that samples it. The enables and the readback therefore show the new value one cycle after the stimulus, and the read itself adds no latency. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then returns the bus to a read of 87h with the write and wake inputs low, so no further state change can occur, and samples shortly after that falling edge. This placement also means an ignored write or a wake that must not clear PD is observed in the register before any later stimulus.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
   localparam int IDL_BIT = 0;
   localparam int PD_BIT  = 1;
   localparam int GF0_BIT = 2;
   localparam int GF1_BIT = 3;
   localparam int POF_BIT = 4;
   localparam int USED_W  = 5;

   typedef struct packed {
      logic gf1;
      logic gf0;
      logic pd;
      logic idl;
   } pctl_mode_t;
endpackage

// File: rtl/pwr_ctl_cold_flag.sv
module pwr_ctl_cold_flag (
   input  logic clk,
   input  logic por_i,
   input  logic sys_rst_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic pof_o
);
   logic pof_q;

   // Only power-on reset raises the flag; software can only lower it.
   always_ff @(posedge clk) begin
      if (por_i)
         pof_q <= 1'b1;
      else if (wr_i && !wbit_i)
         pof_q <= 1'b0;
   end

   assign pof_o = pof_q;

   assert_por_sets_pof_R2: assert property (@(posedge clk) por_i |=> pof_q);

   assert_rst_keeps_pof_R3: assert property (@(posedge clk) disable iff (por_i)
      (sys_rst_i && !wr_i) |=> (pof_q == $past(pof_q)));

   assert_sw_clear_pof_R4: assert property (@(posedge clk) disable iff (por_i)
      (wr_i && !wbit_i) |=> !pof_q);

   assert_sw_no_set_pof_R4: assert property (@(posedge clk) disable iff (por_i)
      (wr_i && wbit_i && !pof_q) |=> !pof_q);
endmodule

// File: rtl/pwr_ctl_mode.sv
module pwr_ctl_mode
   import pwr_ctl_pkg::*;
#(
   parameter bit PD_WAKE_EXT = 1'b1
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       sys_rst_i,
   input  logic       wr_i,
   input  pctl_mode_t wval_i,
   input  logic       irq_wake_i,
   input  logic       ext_wake_i,
   output pctl_mode_t mode_o
);
   pctl_mode_t mode_q, mode_d;
   logic       pd_wake;

   generate
      if (PD_WAKE_EXT) begin : g_ext_pd_wake
         assign pd_wake = ext_wake_i;
      end else begin : g_reset_only_pd_wake
         assign pd_wake = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_d = mode_q;
      if (wr_i) begin
         mode_d.gf1 = wval_i.gf1;
         mode_d.gf0 = wval_i.gf0;
         mode_d.pd  = wval_i.pd;
         mode_d.idl = wval_i.idl & ~wval_i.pd;   // power-down outranks idle
      end
      if (irq_wake_i || ext_wake_i)
         mode_d.idl = 1'b0;
      if (pd_wake)
         mode_d.pd = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (por_i || sys_rst_i)
         mode_q <= '0;
      else
         mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   assert_reset_clears_mode_R3: assert property (@(posedge clk)
      (por_i || sys_rst_i) |=> (mode_q == '0));

   assert_wake_beats_write_R11: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (wr_i && irq_wake_i) |=> (!mode_q.idl && mode_q.gf1 == $past(wval_i.gf1)
                                && mode_q.gf0 == $past(wval_i.gf0)));
endmodule

// File: rtl/pwr_ctl_clk_en.sv
module pwr_ctl_clk_en
   import pwr_ctl_pkg::*;
(
   input  pctl_mode_t mode_i,
   output logic       cpu_en_o,
   output logic       per_en_o,
   output logic       osc_en_o
);
   // With the oscillator stopped no clock runs; idle stops only the CPU.
   always_comb begin
      osc_en_o = ~mode_i.pd;
      per_en_o = osc_en_o;
      cpu_en_o = osc_en_o & ~mode_i.idl;
   end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
   import pwr_ctl_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 'h87,
   parameter bit                PD_WAKE_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              por_i,
   input  logic              sys_rst_i,
   input  logic [ADDR_W-1:0] sfr_addr_i,
   input  logic              sfr_wr_i,
   input  logic [DATA_W-1:0] sfr_wdata_i,
   output logic [DATA_W-1:0] sfr_rdata_o,
   input  logic              irq_wake_i,
   input  logic              ext_wake_i,
   output logic              cpu_clk_en_o,
   output logic              per_clk_en_o,
   output logic              osc_en_o
);
   localparam int SPARE_W = DATA_W - USED_W;

   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("pwr_ctl_reg: DATA_W must hold %0d bits", USED_W);
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("pwr_ctl_reg: ADDR_W must be positive");
      end
   endgenerate

   logic       hit;
   logic       hit_wr;
   logic       pof;
   pctl_mode_t wval;
   pctl_mode_t mode;
   logic       unused_spare;

   assign hit    = (sfr_addr_i == REG_ADDR);
   assign hit_wr = hit && sfr_wr_i;

   assign wval.gf1 = sfr_wdata_i[GF1_BIT];
   assign wval.gf0 = sfr_wdata_i[GF0_BIT];
   assign wval.pd  = sfr_wdata_i[PD_BIT];
   assign wval.idl = sfr_wdata_i[IDL_BIT];

   generate
      if (SPARE_W > 0) begin : g_spare
         assign unused_spare = ^sfr_wdata_i[DATA_W-1:USED_W];
      end else begin : g_no_spare
         assign unused_spare = 1'b0;
      end
   endgenerate

   pwr_ctl_cold_flag u_flag (
      .clk       (clk),
      .por_i     (por_i),
      .sys_rst_i (sys_rst_i),
      .wr_i      (hit_wr),
      .wbit_i    (sfr_wdata_i[POF_BIT]),
      .pof_o     (pof)
   );

   pwr_ctl_mode #(.PD_WAKE_EXT(PD_WAKE_EXT)) u_mode (
      .clk        (clk),
      .por_i      (por_i),
      .sys_rst_i  (sys_rst_i),
      .wr_i       (hit_wr),
      .wval_i     (wval),
      .irq_wake_i (irq_wake_i),
      .ext_wake_i (ext_wake_i),
      .mode_o     (mode)
   );

   pwr_ctl_clk_en u_en (
      .mode_i   (mode),
      .cpu_en_o (cpu_clk_en_o),
      .per_en_o (per_clk_en_o),
      .osc_en_o (osc_en_o)
   );

   always_comb begin
      sfr_rdata_o = '0;
      if (hit) begin
         sfr_rdata_o[POF_BIT] = pof;
         sfr_rdata_o[GF1_BIT] = mode.gf1;
         sfr_rdata_o[GF0_BIT] = mode.gf0;
         sfr_rdata_o[PD_BIT]  = mode.pd;
         sfr_rdata_o[IDL_BIT] = mode.idl;
      end
   end

   assert_idle_cpu_only_R6: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (hit_wr && sfr_wdata_i[IDL_BIT] && !sfr_wdata_i[PD_BIT] && !irq_wake_i && !ext_wake_i)
      |=> (!cpu_clk_en_o && per_clk_en_o && osc_en_o));

   assert_pd_stops_all_R7: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (hit_wr && sfr_wdata_i[PD_BIT] && !(PD_WAKE_EXT && ext_wake_i))
      |=> (!cpu_clk_en_o && !per_clk_en_o && !osc_en_o));

   assert_pd_over_idl_R8: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (hit_wr && sfr_wdata_i[PD_BIT] && sfr_wdata_i[IDL_BIT]) |=> !mode.idl);

   assert_irq_wakes_cpu_R9: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (irq_wake_i && osc_en_o && !(hit_wr && sfr_wdata_i[PD_BIT])) |=> cpu_clk_en_o);

   assert_irq_keeps_pd_R9: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (irq_wake_i && !osc_en_o && !hit_wr && !(PD_WAKE_EXT && ext_wake_i)) |=> !osc_en_o);

   generate
      if (PD_WAKE_EXT) begin : g_chk_ext
         assert_ext_wakes_all_R10: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
            (ext_wake_i && !hit_wr) |=> (osc_en_o && cpu_clk_en_o && per_clk_en_o));
      end
   endgenerate

   assert_other_addr_ignored_R12: assert property (@(posedge clk) disable iff (por_i || sys_rst_i)
      (sfr_wr_i && !hit && !irq_wake_i && !ext_wake_i) |=> $stable(mode));
endmodule

// File: tb/pwr_ctl_reg_tb_top.sv
`timescale 1ns/100ps
module pwr_ctl_reg_tb_top;
   localparam logic [7:0] REGA = 8'h87;

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] wd;
      logic       wr;
      logic       irq;
      logic       ext;
      logic [7:0] rd;
      logic [2:0] en;   // {cpu, per, osc}
      logic [3:0] req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h87, 8'h1C, 1'b1, 1'b0, 1'b0, 8'h1C, 3'b111, 4'd5},  // R5 flags set, POF kept
      '{8'h87, 8'h04, 1'b1, 1'b0, 1'b0, 8'h04, 3'b111, 4'd4},  // R4 clear POF
      '{8'h87, 8'h15, 1'b1, 1'b0, 1'b0, 8'h05, 3'b011, 4'd6},  // R6 idle, R4 no set
      '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h04, 3'b111, 4'd9},  // R9 irq leaves idle
      '{8'h87, 8'h06, 1'b1, 1'b0, 1'b0, 8'h06, 3'b000, 4'd7},  // R7 power-down
      '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h06, 3'b000, 4'd9},  // R9 irq keeps PD
      '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h04, 3'b111, 4'd10}, // R10 ext wake
      '{8'h87, 8'h0B, 1'b1, 1'b0, 1'b0, 8'h0A, 3'b000, 4'd8},  // R8 PD over IDL
      '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 3'b111, 4'd10}, // R10 ext wake
      '{8'h86, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h08, 3'b111, 4'd12}, // R12 other address
      '{8'h87, 8'h09, 1'b1, 1'b1, 1'b0, 8'h08, 3'b111, 4'd11}, // R11 wake beats write
      '{8'h87, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 3'b111, 4'd5}   // R5 flags clear
   };

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       srst = 1'b0;
   logic [7:0] addr = 8'h87;
   logic       wr = 1'b0;
   logic [7:0] wd = 8'h00;
   logic       irq = 1'b0;
   logic       ext = 1'b0;
   logic [7:0] rd;
   logic       cpu_en, per_en, osc_en;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_ctl_reg dut_i (
      .clk          (clk),
      .por_i        (por),
      .sys_rst_i    (srst),
      .sfr_addr_i   (addr),
      .sfr_wr_i     (wr),
      .sfr_wdata_i  (wd),
      .sfr_rdata_o  (rd),
      .irq_wake_i   (irq),
      .ext_wake_i   (ext),
      .cpu_clk_en_o (cpu_en),
      .per_clk_en_o (per_en),
      .osc_en_o     (osc_en)
   );

   task automatic check(input string req, input logic [7:0] exp_rd, input logic [2:0] exp_en);
      checks++;
      if (rd !== exp_rd || {cpu_en, per_en, osc_en} !== exp_en) begin
         fails++;
         $display("FAIL %s rd=%02h en=%03b expected rd=%02h en=%03b",
                  req, rd, {cpu_en, per_en, osc_en}, exp_rd, exp_en);
      end
   endtask

   // Drive on a falling edge, let one rising edge act, then park the bus on a read.
   task automatic step(input logic [7:0] a, input logic [7:0] d, input logic w,
                       input logic i, input logic e);
      @(negedge clk);
      addr = a; wd = d; wr = w; irq = i; ext = e;
      @(posedge clk);
      @(negedge clk);
      addr = REGA; wr = 1'b0; irq = 1'b0; ext = 1'b0; wd = 8'h00;
      #0.5;
   endtask

   task automatic do_reset(input logic p, input logic s);
      @(negedge clk);
      por = p; srst = s; wr = 1'b0; irq = 1'b0; ext = 1'b0;
      @(posedge clk);
      @(negedge clk);
      por = 1'b0; srst = 1'b0; addr = REGA;
      #0.5;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(posedge clk);
      @(negedge clk);
      por = 1'b0;
      #0.5;
      check("R2 power-on state", 8'h10, 3'b111);

      for (int k = 0; k < NV; k++) begin
         step(VECS[k].addr, VECS[k].wd, VECS[k].wr, VECS[k].irq, VECS[k].ext);
         check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].rd, VECS[k].en);
      end

      // R1: other addresses read zero
      addr = 8'h88;
      #0.5;
      check("R1 other address reads 0", 8'h00, 3'b111);
      addr = REGA;
      #0.5;

      // R1: upper bits read 0 after writing ones there (bit4=0 keeps POF clear)
      step(REGA, 8'hE0, 1'b1, 1'b0, 1'b0);
      check("R1 spare bits read 0", 8'h00, 3'b111);

      // R3: general reset with POF clear keeps it clear and clears the mode bits
      step(REGA, 8'h0D, 1'b1, 1'b0, 1'b0);
      check("R6 idle before reset", 8'h0D, 3'b011);
      do_reset(1'b0, 1'b1);
      check("R3 general reset, POF stays 0", 8'h00, 3'b111);

      // R2: power-on reset sets POF and clears flags and power-down
      step(REGA, 8'h0E, 1'b1, 1'b0, 1'b0);
      check("R7 power-down before POR", 8'h0E, 3'b000);
      do_reset(1'b1, 1'b0);
      check("R2 power-on reset", 8'h10, 3'b111);

      // R3: general reset keeps POF set and wakes from power-down
      step(REGA, 8'h1A, 1'b1, 1'b0, 1'b0);
      check("R8 write with POF kept", 8'h1A, 3'b000);
      do_reset(1'b0, 1'b1);
      check("R3 general reset, POF stays 1", 8'h10, 3'b111);

      // R12: write to another address during idle does nothing
      step(REGA, 8'h11, 1'b1, 1'b0, 1'b0);
      step(8'h80, 8'h02, 1'b1, 1'b0, 1'b0);
      check("R12 idle unchanged by other address", 8'h11, 3'b011);

      finish_run();
   end
endmodule